// File: doc/BRIEF.md
# Verified Write Retry Sequencer

This block stands between a bus master in the CPU clock domain and a slow memory controller that runs on an unrelated clock. The master presents one byte and its address, then is held off with its ready signal low until that byte is known to be in memory. Before asking for the write, the sequencer waits until the controller reflects back the address and data it has latched. It commits only when both agree with what was presented. Completion is taken from the controller's done indication, not from a fixed wait count. After the write, the sequencer reads the same location back. If the value differs, it runs the whole sequence again, as many times as needed.

Requests and completions cross the clock boundary as toggles. The sequencer flips one request line per command, with a direction bit beside it. It recognises each flip of the returned done line once, after a small synchronizer. A per-write retry counter and a small set of debug registers show how the last write went. The debug registers are selected by index and hold the last value written and the last address, one byte at a time, least-significant byte first.

Top module: `write_retry_seq`

## Requirements
- R1: After reset, `m_ready` is low, `c_req_tgl` is low, `retry_cnt` is 0, and every debug register reads 0.
- R2: Once a write is accepted, `m_ready` stays low until the write has been read back correctly. It then goes high for exactly one cycle.
- R3: No write command is issued while the echoed address or echoed data differs from the presented values. The sequencer waits with no time limit.
- R4: A write command is a single flip of `c_req_tgl` with `c_op_wr` = 1, while `c_addr`/`c_wdata` hold the master's address and byte. The byte lands at that address.
- R5: After the done flip for a write, exactly one read command follows: a flip of `c_req_tgl` with `c_op_wr` = 0 at the same address.
- R6: When the read-back byte differs from the written byte, the sequence restarts from presentation, a new write is committed, and `retry_cnt` goes up by one.
- R7: `retry_cnt` counts the reissues of the current write. It saturates at 255 and clears to 0 when the next write is accepted.
- R8: `dbg_sel` = 0 reads the last completed write's byte. `dbg_sel` = k (k = 1..3 at the default 24-bit address) reads address byte k-1, with byte 0 being bits 7:0. These registers change only when a write completes.
- R9: A flip of `c_done_tgl` while no command is outstanding is ignored. It neither raises `m_ready` nor issues a command, and it does not complete a later command.
- R10: The data path is 8 bits per request, and the address is `AW` bits wide (default 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master write request, held until `m_ready` |
| m_addr | input | AW | Master write address |
| m_wdata | input | 8 | Master write byte |
| m_ready | output | 1 | One-cycle pulse when the write is verified |
| c_addr | output | AW | Address presented to the controller |
| c_wdata | output | 8 | Byte presented to the controller |
| c_op_wr | output | 1 | Command direction: 1 write, 0 read |
| c_req_tgl | output | 1 | Command toggle, one flip per command |
| c_echo_addr | input | AW | Address the controller has latched |
| c_echo_data | input | 8 | Byte the controller has latched |
| c_done_tgl | input | 1 | Completion toggle from the controller |
| c_rdata | input | 8 | Read-back byte, valid when done flips |
| retry_cnt | output | 8 | Reissues of the current write, saturating |
| dbg_sel | input | SELW | Debug register index |
| dbg_rdata | output | 8 | Selected debug byte |

## Verification
The main function is exercised with four kinds of controller behaviour. A clean controller separates a correct single pass from any spurious retry. An echo held wrong for many cycles shows that commit waits for the reflected address. Writes that are silently dropped a few times show that the read-back comparison reissues and counts. A run of several hundred drops shows that the counter saturates and still reaches the right byte. Address patterns with distinct values in every byte also expose byte-order mistakes in the debug registers. A done flip sent while idle shows that stray completions are not taken as finished commands.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRESENT,
    ST_WAIT_ECHO,
    ST_COMMIT,
    ST_WAIT_DONE,
    ST_READBACK,
    ST_RB_WAIT,
    ST_COMPARE,
    ST_ACK
  } wrs_state_e;

endpackage

// File: rtl/wrs_toggle_rx.sv
// Synchronises an incoming toggle and turns each flip into a one-cycle pulse.
module wrs_toggle_rx #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic flip_pulse
);

  logic synced;
  logic seen_q;

  generate
    if (STAGES < 2) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= tgl_in;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], tgl_in};
      end
      assign synced = chain_q[STAGES-1];
    end
  endgenerate

  // The seen copy always follows, so a flip is reported exactly once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= synced;
  end

  assign flip_pulse = synced ^ seen_q;

endmodule

// File: rtl/wrs_ctrl.sv
// Sequencing state machine: present, echo check, commit, done, read back, compare.
module wrs_ctrl
  import wrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic m_valid,
  input  logic echo_ok,
  input  logic done_pulse,
  input  logic rb_ok,
  output logic accept,
  output logic commit,
  output logic rb_issue,
  output logic rb_capture,
  output logic retry,
  output logic ack
);

  wrs_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    commit     = 1'b0;
    rb_issue   = 1'b0;
    rb_capture = 1'b0;
    retry      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (m_valid) begin
          accept  = 1'b1;
          state_d = ST_PRESENT;
        end
      end
      ST_PRESENT:   state_d = ST_WAIT_ECHO;
      ST_WAIT_ECHO: if (echo_ok) state_d = ST_COMMIT;
      ST_COMMIT: begin
        commit  = 1'b1;
        state_d = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: if (done_pulse) state_d = ST_READBACK;
      ST_READBACK: begin
        rb_issue = 1'b1;
        state_d  = ST_RB_WAIT;
      end
      ST_RB_WAIT: begin
        if (done_pulse) begin
          rb_capture = 1'b1;
          state_d    = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (rb_ok) begin
          state_d = ST_ACK;
        end else begin
          retry   = 1'b1;
          state_d = ST_PRESENT;
        end
      end
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ack = (state_q == ST_ACK);

endmodule

// File: rtl/wrs_dbg_regs.sv
// Last completed write: byte at index 0, address bytes least-significant first after it.
module wrs_dbg_regs
  import wrs_pkg::*;
#(
  parameter int AW   = 24,
  parameter int NB   = (AW + BYTE_W - 1) / BYTE_W,
  parameter int SELW = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     addr_in,
  input  logic [BYTE_W-1:0] data_in,
  input  logic [SELW-1:0]   sel,
  output logic [BYTE_W-1:0] rdata
);

  localparam int PADW = NB * BYTE_W;

  logic [PADW-1:0]   addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [PADW-1:0]   addr_pad;

  generate
    if (PADW > AW) begin : g_pad
      assign addr_pad = {{(PADW-AW){1'b0}}, addr_in};
    end else begin : g_nopad
      assign addr_pad = addr_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_pad;
      data_q <= data_in;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == '0) rdata = data_q;
    for (int k = 0; k < NB; k++) begin
      if (int'(sel) == k + 1) rdata = addr_q[k*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/write_retry_seq.sv
module write_retry_seq
  import wrs_pkg::*;
#(
  parameter int AW          = 24,
  parameter int RCW         = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = (AW + BYTE_W - 1) / BYTE_W,
  localparam int SELW       = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  input  logic [AW-1:0]     m_addr,
  input  logic [BYTE_W-1:0] m_wdata,
  output logic              m_ready,
  output logic [AW-1:0]     c_addr,
  output logic [BYTE_W-1:0] c_wdata,
  output logic              c_op_wr,
  output logic              c_req_tgl,
  input  logic [AW-1:0]     c_echo_addr,
  input  logic [BYTE_W-1:0] c_echo_data,
  input  logic              c_done_tgl,
  input  logic [BYTE_W-1:0] c_rdata,
  output logic [RCW-1:0]    retry_cnt,
  input  logic [SELW-1:0]   dbg_sel,
  output logic [BYTE_W-1:0] dbg_rdata
);

  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] rb_q;
  logic [RCW-1:0]    retry_q;
  logic              req_q;
  logic              opwr_q;

  logic accept, commit, rb_issue, rb_capture, retry, ack;
  logic done_pulse, echo_ok, rb_ok;

  assign echo_ok = (c_echo_addr == addr_q) && (c_echo_data == data_q);
  assign rb_ok   = (rb_q == data_q);

  wrs_toggle_rx #(.STAGES(SYNC_STAGES)) u_done_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgl_in     (c_done_tgl),
    .flip_pulse (done_pulse)
  );

  wrs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_valid    (m_valid),
    .echo_ok    (echo_ok),
    .done_pulse (done_pulse),
    .rb_ok      (rb_ok),
    .accept     (accept),
    .commit     (commit),
    .rb_issue   (rb_issue),
    .rb_capture (rb_capture),
    .retry      (retry),
    .ack        (ack)
  );

  // Captured request, held for the whole sequence including retries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= m_addr;
      data_q <= m_wdata;
    end
  end

  // Command toggle and direction, updated together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      opwr_q <= 1'b0;
    end else if (commit || rb_issue) begin
      req_q  <= ~req_q;
      opwr_q <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rb_q <= '0;
    else if (rb_capture) rb_q <= c_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          retry_q <= '0;
    else if (accept)     retry_q <= '0;
    else if (retry && (retry_q != {RCW{1'b1}}))
                         retry_q <= retry_q + 1'b1;
  end

  wrs_dbg_regs #(.AW(AW), .NB(NB), .SELW(SELW)) u_dbg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ack),
    .addr_in (addr_q),
    .data_in (data_q),
    .sel     (dbg_sel),
    .rdata   (dbg_rdata)
  );

  assign m_ready   = ack;
  assign c_addr    = addr_q;
  assign c_wdata   = data_q;
  assign c_op_wr   = opwr_q;
  assign c_req_tgl = req_q;
  assign retry_cnt = retry_q;

endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
  parameter int AW  = 24,
  parameter int RCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_ready,
  input logic           c_req_tgl,
  input logic           c_op_wr,
  input logic [AW-1:0]  c_addr,
  input logic [7:0]     c_wdata,
  input logic [AW-1:0]  c_echo_addr,
  input logic [7:0]     c_echo_data,
  input logic [RCW-1:0] retry_cnt
);

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  // Write command only after the echo matched (echo check two cycles back).
  assert_commit_after_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(c_req_tgl) && c_op_wr) |->
      $past((c_echo_addr == c_addr) && (c_echo_data == c_wdata), 2));

  assert_cmd_payload_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(c_req_tgl) |-> ($stable(c_addr) && $stable(c_wdata)));

  assert_retry_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |->
      ((retry_cnt == $past(retry_cnt) + 1'b1) || (retry_cnt == '0)));

  assert_retry_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt == {RCW{1'b1}}) |=> ((retry_cnt == {RCW{1'b1}}) || (retry_cnt == '0)));

  assert_no_cmd_on_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |-> $stable(c_req_tgl));

endmodule

bind write_retry_seq wrs_checker #(.AW(AW), .RCW(RCW)) u_wrs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_ready     (m_ready),
  .c_req_tgl   (c_req_tgl),
  .c_op_wr     (c_op_wr),
  .c_addr      (c_addr),
  .c_wdata     (c_wdata),
  .c_echo_addr (c_echo_addr),
  .c_echo_data (c_echo_data),
  .retry_cnt   (retry_cnt)
);

// File: tb/write_retry_seq_test.sv
`timescale 1ns/1ps
module write_retry_seq_test;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          m_valid;
  logic [AW-1:0] m_addr;
  logic [7:0]    m_wdata;
  logic          m_ready;
  logic [AW-1:0] c_addr;
  logic [7:0]    c_wdata;
  logic          c_op_wr;
  logic          c_req_tgl;
  logic [AW-1:0] c_echo_addr;
  logic [7:0]    c_echo_data;
  logic          c_done_tgl;
  logic [7:0]    c_rdata;
  logic [7:0]    retry_cnt;
  logic [1:0]    dbg_sel;
  logic [7:0]    dbg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  write_retry_seq uut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .c_addr(c_addr), .c_wdata(c_wdata), .c_op_wr(c_op_wr),
    .c_req_tgl(c_req_tgl), .c_echo_addr(c_echo_addr), .c_echo_data(c_echo_data),
    .c_done_tgl(c_done_tgl), .c_rdata(c_rdata), .retry_cnt(retry_cnt),
    .dbg_sel(dbg_sel), .dbg_rdata(dbg_rdata)
  );

  // ---------------- controller model ----------------
  logic [7:0]    mem [0:255];
  int            cyc = 0;
  int            echo_bad_until = 0;
  int            drop_upto = 0;
  int            wr_count = 0;
  int            rd_count = 0;
  int            stray_req = 0;
  int            stray_ack = 0;
  logic          resp_last;
  logic          resp_busy;
  logic          resp_op;
  int            resp_lat;
  logic [AW-1:0] resp_addr;
  logic [7:0]    resp_data;
  logic [AW-1:0] last_rd_addr;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      c_done_tgl   <= 1'b0;
      c_rdata      <= 8'h00;
      c_echo_addr  <= '0;
      c_echo_data  <= 8'h00;
      resp_last    <= 1'b0;
      resp_busy    <= 1'b0;
      resp_op      <= 1'b0;
      resp_lat     <= 0;
      last_rd_addr <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      c_echo_addr <= (cyc < echo_bad_until) ? (c_addr ^ 24'h000001) : c_addr;
      c_echo_data <= c_wdata;
      if (stray_req != stray_ack) begin
        stray_ack  <= stray_req;
        c_done_tgl <= ~c_done_tgl;
      end else if (!resp_busy && (c_req_tgl != resp_last)) begin
        resp_last <= c_req_tgl;
        resp_busy <= 1'b1;
        resp_lat  <= 3;
        resp_op   <= c_op_wr;
        resp_addr <= c_addr;
        resp_data <= c_wdata;
      end else if (resp_busy) begin
        if (resp_lat > 1) begin
          resp_lat <= resp_lat - 1;
        end else begin
          resp_busy <= 1'b0;
          if (resp_op) begin
            if (wr_count >= drop_upto) mem[resp_addr[7:0]] <= resp_data;
            wr_count <= wr_count + 1;
          end else begin
            c_rdata      <= mem[resp_addr[7:0]];
            last_rd_addr <= resp_addr;
            rd_count     <= rd_count + 1;
          end
          c_done_tgl <= ~c_done_tgl;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one write; checks the one-cycle ready pulse (R2).
  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, output bit ok);
    int n;
    @(negedge clk);
    m_addr  = a;
    m_wdata = d;
    m_valid = 1'b1;
    ok = 0;
    n  = 0;
    while (n < 20000 && !ok) begin
      @(negedge clk);
      n++;
      if (m_ready) ok = 1;
    end
    m_valid = 1'b0;
    check(ok, "R2 ready pulse", ok, 1);
    @(negedge clk);
    check(m_ready == 1'b0, "R2 single-cycle ready", m_ready, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(m_ready == 1'b0, "R1 ready", m_ready, 0);
    check(c_req_tgl == 1'b0, "R1 req toggle", c_req_tgl, 0);
    check(retry_cnt == 8'd0, "R1 retry", retry_cnt, 0);
    for (int s = 0; s < 4; s++) begin
      dbg_sel = 2'(s);
      #1;
      check(dbg_rdata == 8'h00, "R1 debug", dbg_rdata, 0);
    end
    dbg_sel = 2'd0;
  endtask

  task automatic t_plain(input logic [AW-1:0] a, input logic [7:0] d);
    int w0, r0;
    bit ok;
    w0 = wr_count;
    r0 = rd_count;
    do_write(a, d, ok);
    check(mem[a[7:0]] == d, "R4 byte stored (R10 8-bit path)", mem[a[7:0]], d);
    check(wr_count - w0 == 1, "R4 one commit", wr_count - w0, 1);
    check(rd_count - r0 == 1, "R5 one readback", rd_count - r0, 1);
    check(last_rd_addr == a, "R5 readback address", last_rd_addr, a);
    check(retry_cnt == 8'd0, "R6 no retry when clean", retry_cnt, 0);
  endtask

  task automatic t_echo_wait();
    int w0;
    bit ok;
    w0 = wr_count;
    echo_bad_until = cyc + 40;
    @(negedge clk);
    m_addr = 24'h000042; m_wdata = 8'h77; m_valid = 1'b1;
    repeat (30) @(negedge clk);
    check(wr_count == w0, "R3 no commit with bad echo", wr_count - w0, 0);
    check(m_ready == 1'b0, "R3 master held", m_ready, 0);
    m_valid = 1'b0;
    do_write(24'h000042, 8'h77, ok);
    check(mem[8'h42] == 8'h77, "R3 write after echo ok", mem[8'h42], 8'h77);
    check(wr_count - w0 == 1, "R3 single commit", wr_count - w0, 1);
  endtask

  task automatic t_retry();
    bit ok;
    int w0;
    w0 = wr_count;
    drop_upto = wr_count + 3;
    do_write(24'h000055, 8'hC3, ok);
    check(retry_cnt == 8'd3, "R6 retry count", retry_cnt, 3);
    check(mem[8'h55] == 8'hC3, "R6 eventual store", mem[8'h55], 8'hC3);
    check(wr_count - w0 == 4, "R6 reissued commits", wr_count - w0, 4);
    t_plain(24'h000056, 8'h3C);
    check(retry_cnt == 8'd0, "R7 cleared on next write", retry_cnt, 0);
  endtask

  task automatic t_saturate();
    bit ok;
    drop_upto = wr_count + 300;
    do_write(24'h000060, 8'h9E, ok);
    check(retry_cnt == 8'hFF, "R7 saturation", retry_cnt, 8'hFF);
    check(mem[8'h60] == 8'h9E, "R7 eventual store", mem[8'h60], 8'h9E);
  endtask

  task automatic t_debug();
    bit ok;
    logic [7:0] expv [4];
    do_write(24'hABCDEF, 8'h5D, ok);
    expv = '{8'h5D, 8'hEF, 8'hCD, 8'hAB};
    for (int s = 0; s < 4; s++) begin
      dbg_sel = 2'(s);
      #1;
      check(dbg_rdata == expv[s], "R8 debug byte", dbg_rdata, expv[s]);
    end
    dbg_sel = 2'd0;
    echo_bad_until = cyc + 20;
    @(negedge clk);
    m_addr = 24'h123411; m_wdata = 8'h01; m_valid = 1'b1;
    repeat (10) @(negedge clk);
    check(dbg_rdata == 8'h5D, "R8 held during write", dbg_rdata, 8'h5D);
    m_valid = 1'b0;
    do_write(24'h123411, 8'h01, ok);
    check(dbg_rdata == 8'h01, "R8 updated on completion", dbg_rdata, 8'h01);
  endtask

  task automatic t_stray();
    int w0, r0;
    logic req0;
    w0 = wr_count; r0 = rd_count; req0 = c_req_tgl;
    stray_req++;
    repeat (10) @(negedge clk);
    check(m_ready == 1'b0, "R9 stray done no ready", m_ready, 0);
    check(c_req_tgl == req0, "R9 stray done no command", c_req_tgl, req0);
    t_plain(24'h0000A7, 8'h6B);
    check(rd_count - r0 == 1, "R9 later write completes normally", rd_count - r0, 1);
  endtask

  // ---------------- main ----------------
  initial begin
    rst_n = 1'b0; m_valid = 1'b0; m_addr = '0; m_wdata = '0; dbg_sel = 2'd0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_plain(24'h000010, 8'hA5);
    t_plain(24'hFFFF21, 8'h5A);
    t_plain(24'h123456, 8'h01);
    t_echo_wait();
    t_retry();
    t_saturate();
    t_debug();
    t_stray();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule